// File: doc/BRIEF.md
# Private Interrupt State Bank with Security Filtering

This block holds the per-processor state of 32 private interrupts: IDs 0 to 15 are software-generated and IDs 16 to 31 come from peripherals. For each interrupt it keeps the following state:

- a group bit and a group-modifier bit
- enable, pending and active bits
- an 8-bit priority
- a trigger-type bit
- for the software-generated interrupts, a 2-bit non-secure access field

Software reaches this state through a word-wide register port. Each access carries a secure flag. A global `sec_off` input switches the two-security-state model off.

Writes take effect at the clock edge. Reads are combinational from `addr` and `secure` and have no side effects. When security is on and an access is non-secure, every field that belongs to an interrupt outside non-secure Group 1 is hidden: it reads as zero and ignores writes. Non-secure accesses also see a scaled view of priorities.

The decoded state is exported in parallel toward a priority arbiter. A one-cycle strobe tells the arbiter when software has requested new pending interrupts.

Top module: `irq_bank`

## Requirements
- R1: After reset the group, modifier, enable, pending, active, priority, peripheral trigger and access-control fields are all zero, and `pe_sleep` is 1.
- R2: Enable, pending and active each have a set register and a clear register: set at 0x100/0x200/0x300 and clear at 0x180/0x280/0x380. A 1 in the write data sets or clears the bit of that interrupt ID, and a 0 leaves it unchanged. A read of either register of a pair returns the current state.
- R3: With `sec_off`=0 and `secure`=0, every per-interrupt bit or field of an interrupt whose class is not non-secure Group 1 reads as zero and ignores writes. This covers enable, pending, active, priority and trigger.
- R4: With `sec_off`=0 and `secure`=0, a visible priority reads as (p<<1)&0xFF. A write of byte w to it stores 0x80|(w>>1).
- R5: Priorities occupy byte addresses 0x400–0x41F, one byte per ID. Word k holds IDs 4k..4k+3, with the lowest byte holding the lowest ID. Only byte lanes with `wstrb` set are written; all other registers ignore `wstrb`.
- R6: Trigger configuration uses 2 bits per ID, and bit 1 of each pair set means edge-triggered. 0x C00 covers IDs 0–15 and always reads 0xAAAAAAAA for visible IDs; writes to it are ignored. 0xC04 covers IDs 16–31 and is writable; `irq_edge` reflects it.
- R7: The group register at 0x080 reads as zero and ignores writes for non-secure accesses while security is on. The modifier register at 0xD00 and the access-control register at 0xE00 are accessible only when `sec_off`=0 and `secure`=1; otherwise they read as zero and ignore writes.
- R8: The wake register at 0x000 reads {bit2 = sleep, bit1 = sleep}. A write loads the sleep flag from bit 1. For non-secure accesses while security is on, it reads as zero and ignores writes.
- R9: A write to 0x200 drives `upd_strobe` high for exactly the following cycle, and no other access raises it.
- R10: Reads of unmapped offsets return zero, and writes to them change no state.
- R11: `irq_grp[2i+1:2i]` gives the class of ID i: 00 = Group 0, 01 = non-secure Group 1, 10 = secure Group 1. With `sec_off`=1 the class is 01 if the group bit is 1 and 00 otherwise. With `sec_off`=0 the class is 01 if the group bit is 1, otherwise 10 if the modifier bit is 1, otherwise 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_off | input | 1 | 1 = single security state |
| secure | input | 1 | Access is secure |
| wr_en | input | 1 | Write this cycle |
| addr | input | 12 | Byte address, word aligned |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte lanes for priority writes |
| rdata | output | 32 | Read data for `addr` |
| irq_en | output | 32 | Enable bits |
| irq_pend | output | 32 | Pending bits |
| irq_act | output | 32 | Active bits |
| irq_edge | output | 32 | 1 = edge-triggered |
| irq_prio | output | 256 | Priority of ID i at [8i+7:8i] |
| irq_grp | output | 64 | Class of each ID |
| pe_sleep | output | 1 | Processor sleep flag |
| upd_strobe | output | 1 | New pending request |

## Verification
The properties assume that `addr` is word aligned, and that `sec_off` and `secure` are stable during the cycle in which a write is sampled. The stimulus changes them only at falling edges, and only between operations. Every address is drawn from a list of word-aligned offsets that mixes mapped registers with a few holes. Because the filter depends on the group state as it stands before a write, the random mix deliberately reprograms group and modifier between visibility-sensitive writes.

// File: rtl/irq_bank.sv
module irq_bank (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sec_off,
  input  logic         secure,
  input  logic         wr_en,
  input  logic [11:0]  addr,
  input  logic [31:0]  wdata,
  input  logic [3:0]   wstrb,
  output logic [31:0]  rdata,
  output logic [31:0]  irq_en,
  output logic [31:0]  irq_pend,
  output logic [31:0]  irq_act,
  output logic [31:0]  irq_edge,
  output logic [255:0] irq_prio,
  output logic [63:0]  irq_grp,
  output logic         pe_sleep,
  output logic         upd_strobe
);
  localparam logic [11:0] A_WAKE = 12'h000, A_GRP = 12'h080,
    A_ENS = 12'h100, A_ENC = 12'h180, A_PDS = 12'h200, A_PDC = 12'h280,
    A_ACS = 12'h300, A_ACC = 12'h380, A_CF0 = 12'hC00, A_CF1 = 12'hC04,
    A_MOD = 12'hD00, A_NSA = 12'hE00;

  logic [31:0] grp_q, mod_q, en_q, pend_q, act_q, nsac_q;
  logic [15:0] cfg_q;
  logic [7:0]  prio_q [32];
  logic        sleep_q, upd_q;
  logic [31:0] vis;
  logic [11:0] a;
  logic        ns_view, priv, is_prio;

  assign a       = {addr[11:2], 2'b00};
  assign ns_view = !sec_off && !secure;
  assign priv    = !sec_off && secure;
  assign is_prio = (a[11:5] == 7'b0100000);

  genvar g;
  generate
    for (g = 0; g < 32; g++) begin : g_id
      assign irq_grp[2*g+:2]  = (sec_off || grp_q[g]) ? {1'b0, grp_q[g]} : {mod_q[g], 1'b0};
      assign vis[g]           = !ns_view || grp_q[g];
      assign irq_prio[8*g+:8] = prio_q[g];
    end
  endgenerate

  assign irq_en     = en_q;
  assign irq_pend   = pend_q;
  assign irq_act    = act_q;
  assign irq_edge   = {cfg_q, 16'hFFFF};
  assign pe_sleep   = sleep_q;
  assign upd_strobe = upd_q;

  always_comb begin
    rdata = '0;
    case (a)
      A_WAKE: if (!ns_view) rdata = {29'd0, sleep_q, sleep_q, 1'b0};
      A_GRP:  if (!ns_view) rdata = grp_q;
      A_ENS, A_ENC: rdata = en_q & vis;
      A_PDS, A_PDC: rdata = pend_q & vis;
      A_ACS, A_ACC: rdata = act_q & vis;
      A_CF0: for (int i = 0; i < 16; i++) rdata[2*i+1] = vis[i];
      A_CF1: for (int i = 0; i < 16; i++) rdata[2*i+1] = cfg_q[i] & vis[16+i];
      A_MOD: if (priv) rdata = mod_q;
      A_NSA: if (priv) rdata = nsac_q;
      default:
        if (is_prio)
          for (int b = 0; b < 4; b++) begin
            if (vis[{addr[4:2], 2'(b)}])
              rdata[8*b+:8] = ns_view ? {prio_q[{addr[4:2], 2'(b)}][6:0], 1'b0}
                                      : prio_q[{addr[4:2], 2'(b)}];
          end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_q <= '0; mod_q <= '0; en_q <= '0; pend_q <= '0; act_q <= '0;
      nsac_q <= '0; cfg_q <= '0; sleep_q <= 1'b1; upd_q <= 1'b0;
      for (int i = 0; i < 32; i++) prio_q[i] <= '0;
    end else begin
      upd_q <= wr_en && (a == A_PDS);
      if (wr_en) begin
        case (a)
          A_WAKE: if (!ns_view) sleep_q <= wdata[1];
          A_GRP:  if (!ns_view) grp_q <= wdata;
          A_ENS:  en_q   <= en_q   |  (wdata & vis);
          A_ENC:  en_q   <= en_q   & ~(wdata & vis);
          A_PDS:  pend_q <= pend_q |  (wdata & vis);
          A_PDC:  pend_q <= pend_q & ~(wdata & vis);
          A_ACS:  act_q  <= act_q  |  (wdata & vis);
          A_ACC:  act_q  <= act_q  & ~(wdata & vis);
          A_CF1:  for (int i = 0; i < 16; i++) if (vis[16+i]) cfg_q[i] <= wdata[2*i+1];
          A_MOD:  if (priv) mod_q <= wdata;
          A_NSA:  if (priv) nsac_q <= wdata;
          default:
            if (is_prio)
              for (int b = 0; b < 4; b++) begin
                if (wstrb[b] && vis[{addr[4:2], 2'(b)}])
                  prio_q[{addr[4:2], 2'(b)}] <= ns_view ? {1'b1, wdata[8*b+1+:7]}
                                                        : wdata[8*b+:8];
              end
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         sec_off,
  input logic         secure,
  input logic         wr_en,
  input logic [11:0]  addr,
  input logic [31:0]  wdata,
  input logic [3:0]   wstrb,
  input logic [31:0]  irq_en,
  input logic [31:0]  irq_pend,
  input logic [255:0] irq_prio,
  input logic [63:0]  irq_grp,
  input logic         pe_sleep,
  input logic         upd_strobe
);
  logic [31:0] nsg1;
  logic        ns_acc;
  logic [4:0]  lane0;
  always_comb for (int i = 0; i < 32; i++) nsg1[i] = (irq_grp[2*i+:2] == 2'b01);
  assign ns_acc = !sec_off && !secure;
  assign lane0  = {addr[4:2], 2'b00};

  AST_STROBE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |-> $past(wr_en && addr[11:2] == 10'h080)); // R9
  AST_SET_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ns_acc && addr[11:2] == 10'h080) |=> ((irq_pend & $past(wdata)) == $past(wdata))); // R2
  AST_CLR_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ns_acc && addr[11:2] == 10'h060) |=> ((irq_en & $past(wdata)) == 32'd0)); // R2
  AST_NS_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ns_acc) |=> (((irq_en ^ $past(irq_en)) & ~$past(nsg1)) == 32'd0)); // R3
  AST_NS_PRIO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ns_acc && addr[11:5] == 7'b0100000 && wstrb[0] && nsg1[lane0])
      |=> irq_prio[8*$past(lane0)+7]); // R4
  AST_WAKE_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ns_acc && addr[11:2] == 10'h000) |=> $stable(pe_sleep)); // R8
endmodule

bind irq_bank irq_bank_chk chk_i (.*);

// File: tb/irq_bank_tb_top.sv
module irq_bank_tb_top;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0, sec_off = 0, secure = 1, wr_en = 0;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [3:0]  wstrb = 0;
  logic [31:0] rdata, irq_en, irq_pend, irq_act, irq_edge;
  logic [255:0] irq_prio;
  logic [63:0] irq_grp;
  logic pe_sleep, upd_strobe;
  int nvec = 0, nbad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  irq_bank dut_i (.*);

  logic [31:0] m_grp, m_mod, m_en, m_pend, m_act, m_nsac;
  logic [15:0] m_cfg;
  logic [7:0]  m_prio [32];
  logic        m_sleep;

  function automatic logic [1:0] cls(int i);
    if (m_grp[i]) return 2'b01;
    if (!sec_off && m_mod[i]) return 2'b10;
    return 2'b00;
  endfunction
  function automatic logic vis(int i, logic sec);
    return sec_off || sec || m_grp[i];
  endfunction
  function automatic logic [31:0] vmask(logic sec);
    logic [31:0] v;
    for (int i = 0; i < 32; i++) v[i] = vis(i, sec);
    return v;
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a, logic sec);
    logic [31:0] r = 0;
    logic ns = !sec_off && !sec;
    case (a)
      12'h000: if (!ns) r = m_sleep ? 32'h6 : 32'h0;
      12'h080: if (!ns) r = m_grp;
      12'h100, 12'h180: r = m_en & vmask(sec);
      12'h200, 12'h280: r = m_pend & vmask(sec);
      12'h300, 12'h380: r = m_act & vmask(sec);
      12'hC00: for (int i = 0; i < 16; i++) r[2*i+1] = vis(i, sec);
      12'hC04: for (int i = 0; i < 16; i++) r[2*i+1] = m_cfg[i] && vis(16+i, sec);
      12'hD00: if (!sec_off && sec) r = m_mod;
      12'hE00: if (!sec_off && sec) r = m_nsac;
      default: if (a >= 12'h400 && a < 12'h420)
        for (int b = 0; b < 4; b++) begin
          int id = (a - 12'h400) + b;
          if (vis(id, sec)) r[8*b+:8] = ns ? (m_prio[id] << 1) : m_prio[id];
        end
    endcase
    return r;
  endfunction

  task automatic m_write(logic [11:0] a, logic [31:0] d, logic [3:0] s, logic sec);
    logic ns = !sec_off && !sec;
    logic [31:0] v = vmask(sec);
    case (a)
      12'h000: if (!ns) m_sleep = d[1];
      12'h080: if (!ns) m_grp = d;
      12'h100: m_en = m_en | (d & v);
      12'h180: m_en = m_en & ~(d & v);
      12'h200: m_pend = m_pend | (d & v);
      12'h280: m_pend = m_pend & ~(d & v);
      12'h300: m_act = m_act | (d & v);
      12'h380: m_act = m_act & ~(d & v);
      12'hC04: for (int i = 0; i < 16; i++) if (v[16+i]) m_cfg[i] = d[2*i+1];
      12'hD00: if (!sec_off && sec) m_mod = d;
      12'hE00: if (!sec_off && sec) m_nsac = d;
      default: if (a >= 12'h400 && a < 12'h420)
        for (int b = 0; b < 4; b++) begin
          int id = (a - 12'h400) + b;
          if (s[b] && v[id]) m_prio[id] = ns ? (8'h80 | (d[8*b+:8] >> 1)) : d[8*b+:8];
        end
    endcase
  endtask

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] s, logic sec);
    @(negedge clk);
    addr = a; wdata = d; wstrb = s; secure = sec; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    m_write(a, d, s, sec);
    check("R9 strobe", {31'd0, upd_strobe}, {31'd0, a == 12'h200});
  endtask

  task automatic rd(string tag, logic [11:0] a, logic sec);
    addr = a; secure = sec; wr_en = 0;
    #1;
    check(tag, rdata, m_read(a, sec));
  endtask

  task automatic chk_state(string tag);
    logic [63:0] eg;
    logic [255:0] ep;
    for (int i = 0; i < 32; i++) begin
      eg[2*i+:2] = cls(i);
      ep[8*i+:8] = m_prio[i];
    end
    check({tag, " R2 en"}, irq_en, m_en);
    check({tag, " R2 pend"}, irq_pend, m_pend);
    check({tag, " R2 act"}, irq_act, m_act);
    check({tag, " R6 edge"}, irq_edge, {m_cfg, 16'hFFFF});
    check({tag, " R11 grp lo"}, irq_grp[31:0], eg[31:0]);
    check({tag, " R11 grp hi"}, irq_grp[63:32], eg[63:32]);
    check({tag, " R5 prio"}, irq_prio[31:0] ^ irq_prio[255:224] ^ irq_prio[127:96],
          ep[31:0] ^ ep[255:224] ^ ep[127:96]);
    check({tag, " R8 sleep"}, {31'd0, pe_sleep}, {31'd0, m_sleep});
  endtask

  localparam logic [11:0] AL [20] = '{12'h000, 12'h080, 12'h100, 12'h180, 12'h200,
    12'h280, 12'h300, 12'h380, 12'h400, 12'h404, 12'h408, 12'h40C, 12'h410,
    12'h41C, 12'hC00, 12'hC04, 12'hD00, 12'hE00, 12'h800, 12'h420};

  initial begin
    m_grp = 0; m_mod = 0; m_en = 0; m_pend = 0; m_act = 0; m_nsac = 0; m_cfg = 0;
    m_sleep = 1;
    for (int i = 0; i < 32; i++) m_prio[i] = 0;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_state("R1 reset");
    for (int k = 0; k < 20; k++) rd("R1 reset read", AL[k], 1);
    rd("R8 wake after reset", 12'h000, 1);
    // R2 set/clear pairs
    wr(12'h100, 32'hF0F0_00FF, 4'hF, 1);
    wr(12'h180, 32'h0000_000F, 4'hF, 1);
    wr(12'h100, 32'h0, 4'hF, 1);
    rd("R2 en set read", 12'h100, 1);
    rd("R2 en clr read", 12'h180, 1);
    check("R2 en value", irq_en, 32'hF0F0_00F0);
    // R7 / R3 group filtering
    wr(12'h080, 32'h0000_FF00, 4'hF, 1);
    rd("R7 ns group raz", 12'h080, 0);
    check("R7 ns group zero", rdata, 32'h0);
    wr(12'h080, 32'hFFFF_FFFF, 4'hF, 0);
    wr(12'h180, 32'hFFFF_FFFF, 4'hF, 0);
    check("R3 ns clear only ns-g1", irq_en, 32'hF0F0_00F0);
    rd("R3 ns en read", 12'h100, 0);
    // R5 priority lanes
    wr(12'h400, 32'h4433_2211, 4'hF, 1);
    rd("R5 word0", 12'h400, 1);
    wr(12'h400, 32'h0000_AA00, 4'h2, 1);
    rd("R5 lane1 only", 12'h400, 1);
    check("R5 lane1 value", rdata, 32'h4433_AA11);
    // R4 non-secure priority view
    wr(12'h408, 32'h0204_0608, 4'hF, 0);
    rd("R4 secure view", 12'h408, 1);
    check("R4 stored", rdata, 32'h8182_8384);
    rd("R4 ns view", 12'h408, 0);
    check("R4 ns read", rdata, 32'h0204_0608);
    wr(12'h400, 32'hFFFF_FFFF, 4'hF, 0);
    rd("R3 ns prio ignored", 12'h400, 1);
    // R6 configuration
    wr(12'hC00, 32'h0, 4'hF, 1);
    rd("R6 sgi cfg", 12'hC00, 1);
    check("R6 sgi fixed", rdata, 32'hAAAA_AAAA);
    wr(12'hC04, 32'hAAAA_0000, 4'hF, 1);
    rd("R6 ppi cfg", 12'hC04, 1);
    check("R6 edge out", irq_edge, 32'hFF00_FFFF);
    // R7 / R11 modifier and access control
    wr(12'hD00, 32'h00F0_0000, 4'hF, 1);
    check("R11 class secure g1", {30'd0, irq_grp[41:40]}, 32'd2);
    wr(12'hE00, 32'h1234_5678, 4'hF, 1);
    rd("R7 nsac secure", 12'hE00, 1);
    rd("R7 nsac ns", 12'hE00, 0);
    sec_off = 1;
    rd("R7 mod sec_off", 12'hD00, 1);
    check("R11 class sec_off", {30'd0, irq_grp[41:40]}, 32'd0);
    wr(12'hD00, 32'h0, 4'hF, 1);
    sec_off = 0;
    rd("R7 mod kept", 12'hD00, 1);
    // R8 wake
    wr(12'h000, 32'h0, 4'hF, 0);
    check("R8 ns wake ignored", {31'd0, pe_sleep}, 32'd1);
    wr(12'h000, 32'h0, 4'hF, 1);
    check("R8 wake cleared", {31'd0, pe_sleep}, 32'd0);
    // R9 strobe
    wr(12'h200, 32'h0001_0000, 4'hF, 1);
    @(negedge clk);
    check("R9 strobe drops", {31'd0, upd_strobe}, 32'd0);
    // R10 unmapped
    wr(12'h800, 32'hFFFF_FFFF, 4'hF, 1);
    rd("R10 unmapped read", 12'h800, 1);
    check("R10 zero", rdata, 32'h0);
    chk_state("R10 state");
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [11:0] a = AL[$urandom_range(19)];
      logic sec = $urandom_range(1);
      if ($urandom_range(7) == 0) sec_off = $urandom_range(1);
      wr(a, $urandom, 4'($urandom), sec);
      rd("R3 rand read", AL[$urandom_range(19)], $urandom_range(1));
      if (n % 8 == 0) chk_state("R2 rand");
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule